// File: doc/BRIEF.md
# Linear Sweep Direct Digital Synthesis Core

This block is the numeric heart of a direct digital synthesizer that can ramp its output frequency linearly. A sweep offset register grows by a programmed increment once per sweep step, and the tuning word it produces is the start word plus that offset. A down-counter running on the sync clock sets how long each step lasts. The tuning word is added every cycle into a phase accumulator. The top phase bits address a quarter-wave amplitude table, which gives a cosine or a sine sample.

Every setting arrives on pending inputs and takes effect on the clock edge that samples the update strobe. That same strobe can also start the current step's countdown again, or zero either accumulator for one sync-clock period. These one-shot actions are separate from the static clear bits, which hold an accumulator at zero for as long as they are active. Priority runs from static clear, to strobe-driven clear, to normal operation.

Top module: `sweep_dds_core`

## Requirements
- R1: While reset is asserted and after it is released, the active settings are all zero, and `ftw_o`, `phase_o` and `amp_o` read zero until the first clock edge after release.
- R2: Pending settings are copied into the active settings only on a clock edge where `upd_i` is 1. Changing the pending inputs while `upd_i` is 0 leaves all outputs on their previous course.
- R3: With sweep enabled and nothing else acting, the countdown is loaded with the active ramp value R at each step, and the sweep offset grows by the increment once every R+1 cycles. `ftw_o` always equals the active start word plus the offset, modulo 2^32.
- R4: With the pending reload bit at 0, a strobe does not touch the countdown. With it at 1 and sweep enabled, a strobe loads the countdown with the pending ramp value, which restarts the current step.
- R5: A sweep step never takes the offset beyond the span (end word minus start word, or 0 if end < start). The step is clamped to the span and the offset then holds, so `ftw_o` stops at the end word.
- R6: A strobe with the pending frequency auto-clear bit at 1 zeroes the offset on the next edge, so `ftw_o` returns to the start word. It also loads the countdown with the pending ramp value, and sweeping resumes from there.
- R7: A strobe with the pending phase auto-clear bit at 1 makes `phase_o` zero after that edge. On the following edge the phase resumes adding the tuning word.
- R8: A strobe with both auto-clear bits at 0 leaves the offset and the phase on the values they would otherwise have taken.
- R9: While the active frequency (or phase) static clear bit is 1, the offset (or phase) is held at zero and the countdown is parked at the active ramp value. A static clear overrides a strobe-driven clear.
- R10: When no clear acts, `phase_o` grows by `ftw_o` every cycle, modulo 2^32.
- R11: `amp_o` is a signed 12-bit sample, registered one cycle after the phase it is taken from. With p the top 10 bits of the phase, it is round(2047*cos(2π(p+0.5)/1024)) when the active sine bit is 0, and the same with sin when it is 1, within 1 LSB. It never reads -2048.
- R12: With sweep disabled in the active settings, the offset holds its value and the countdown stays parked at the active ramp value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_i | input | 1 | Update strobe: applies pending settings and fires the armed one-shot actions |
| pend_start_i | input | 32 | Pending sweep start tuning word |
| pend_end_i | input | 32 | Pending sweep end tuning word |
| pend_step_i | input | 32 | Pending per-step tuning increment |
| pend_ramp_i | input | 16 | Pending ramp countdown value (step lasts value+1 cycles) |
| pend_sweep_i | input | 1 | Pending sweep enable |
| pend_fhold_i | input | 1 | Pending frequency static clear |
| pend_phold_i | input | 1 | Pending phase static clear |
| pend_fauto_i | input | 1 | Pending frequency auto-clear on strobe |
| pend_pauto_i | input | 1 | Pending phase auto-clear on strobe |
| pend_rreload_i | input | 1 | Pending ramp countdown restart on strobe |
| pend_sine_i | input | 1 | Pending waveform select: 0 cosine, 1 sine |
| ftw_o | output | 32 | Current tuning word |
| phase_o | output | 32 | Phase accumulator |
| amp_o | output | 12 | Signed amplitude sample |

## Verification
A wrong countdown or offset shows up at `ftw_o` within one step period, that is, R+1 cycles. Once the tuning word has gone wrong, the phase accumulator carries the error for ever, so `phase_o` differs from the cycle after. A misplaced clear or a wrong priority shows on the edge that follows the strobe. An error in the table or in the quadrant folding appears at `amp_o` one cycle after the phase that exposes it. The bench therefore compares all three outputs on every cycle against a model, under directed sweeps, clamps, clears and strobes, and then under long random strobe patterns.

// File: rtl/sdds_pkg.sv
`timescale 1ns/1ps
package sdds_pkg;

  // Single-bit control settings, latched as a group on the update strobe.
  typedef struct packed {
    logic sweep;    // sweep enable
    logic fhold;    // frequency offset static clear
    logic phold;    // phase static clear
    logic fauto;    // frequency clear on strobe
    logic pauto;    // phase clear on strobe
    logic rreload;  // countdown restart on strobe
    logic sine;     // 1: sine, 0: cosine
  } sdds_ctl_t;

  // Quarter-wave sample i of qn: round(amax*sin((2i+1)*pi/(4*qn))),
  // evaluated by a Taylor series so it folds to a constant.
  function automatic int qsin_sample(input int idx, input int qn, input int amax);
    real x;
    real term;
    real acc;
    x    = (2.0 * idx + 1.0) * 3.14159265358979323846 / (4.0 * qn);
    term = x;
    acc  = x;
    for (int k = 1; k < 12; k++) begin
      term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
      acc  = acc + term;
    end
    return $rtoi(acc * amax + 0.5);
  endfunction

endpackage

// File: rtl/sdds_ramp_timer.sv
`timescale 1ns/1ps
module sdds_ramp_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          park_i,      // hold counter at the active ramp value
  input  logic          restart_i,   // strobe-driven reload with the pending value
  input  logic [RW-1:0] restart_val_i,
  input  logic [RW-1:0] ramp_val_i,  // active ramp value
  output logic          tick_o       // a sweep step is due this cycle
);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_d;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    tick_o = 1'b0;
    if (park_i) begin
      cnt_d = ramp_val_i;
    end else if (restart_i) begin
      cnt_d = restart_val_i;
    end else if (at_zero) begin
      cnt_d  = ramp_val_i;
      tick_o = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: an undisturbed countdown moves down by exactly one per cycle.
  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!park_i && !restart_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9, R12: a parked counter sits at the active ramp value.
  assert_park_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
    park_i |=> (cnt_q == $past(ramp_val_i)));

endmodule

// File: rtl/sdds_freq_sweep.sv
`timescale 1ns/1ps
module sdds_freq_sweep #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,    // static clear
  input  logic          clr_i,     // strobe-driven clear
  input  logic          tick_i,    // step due
  input  logic [FW-1:0] start_i,
  input  logic [FW-1:0] end_i,
  input  logic [FW-1:0] step_i,
  output logic [FW-1:0] ftw_o
);

  logic [FW-1:0] off_q;
  logic [FW-1:0] off_d;
  logic [FW-1:0] span;
  logic [FW:0]   sum;

  assign span = (end_i >= start_i) ? (end_i - start_i) : '0;
  assign sum  = {1'b0, off_q} + {1'b0, step_i};

  always_comb begin
    off_d = off_q;
    if (hold_i || clr_i) begin
      off_d = '0;
    end else if (tick_i) begin
      off_d = (sum > {1'b0, span}) ? span : sum[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  assign ftw_o = start_i + off_q;

  // R9: static clear holds the offset at zero.
  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (off_q == '0));

  // R5: a step never carries the offset past the span.
  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_i && !clr_i) |=> (off_q <= $past(span)));

  // R6: strobe clear zeroes the offset on the next edge.
  assert_auto_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (off_q == '0));

endmodule

// File: rtl/sdds_phase_acc.sv
`timescale 1ns/1ps
module sdds_phase_acc #(
  parameter int PW = 32,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          clr_i,
  input  logic [FW-1:0] ftw_i,
  output logic [PW-1:0] phase_o
);

  logic [PW-1:0] ftw_ext;
  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;

  generate
    if (PW > FW) begin : g_pad
      assign ftw_ext = {{(PW-FW){1'b0}}, ftw_i};
    end else begin : g_cut
      assign ftw_ext = ftw_i[FW-1 -: PW];
    end
  endgenerate

  always_comb begin
    if (hold_i || clr_i) ph_d = '0;
    else                 ph_d = ph_q + ftw_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  // R10: with no clear, the phase advances by the tuning word.
  assert_accumulate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !clr_i) |=> (ph_q == $past(ph_q) + $past(ftw_ext)));

  // R7: strobe clear gives zero phase after the edge.
  assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hold_i) |=> (ph_q == '0));

  // R9: static clear holds the phase at zero.
  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (ph_q == '0));

endmodule

// File: rtl/sdds_amp_lut.sv
`timescale 1ns/1ps
module sdds_amp_lut #(
  parameter int AW = 10,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr_i,  // top phase bits
  input  logic                 sine_i,
  output logic signed [DW-1:0] amp_o
);
  import sdds_pkg::*;

  localparam int QB   = AW - 2;
  localparam int QN   = 1 << QB;
  localparam int AMAX = (1 << (DW-1)) - 1;

  logic [DW-2:0] qtab [QN];

  generate
    for (genvar g = 0; g < QN; g++) begin : g_tab
      assign qtab[g] = (DW-1)'(qsin_sample(g, QN, AMAX));
    end
  endgenerate

  logic [AW-1:0]        a;
  logic [1:0]           quad;
  logic [QB-1:0]        idx;
  logic                 mirror;
  logic                 neg;
  logic signed [DW-1:0] mag;
  logic signed [DW-1:0] amp_d;
  logic signed [DW-1:0] amp_q;

  // Sine is cosine taken a quarter turn earlier.
  assign a      = addr_i - (sine_i ? AW'(QN) : '0);
  assign quad   = a[AW-1 -: 2];
  assign mirror = ~quad[0];
  assign neg    = quad[1] ^ quad[0];
  assign idx    = mirror ? ~a[QB-1:0] : a[QB-1:0];
  assign mag    = $signed({1'b0, qtab[idx]});
  assign amp_d  = neg ? -mag : mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp_q <= '0;
    else        amp_q <= amp_d;
  end

  assign amp_o = amp_q;

  // R11: output stays within the symmetric range.
  assert_amp_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    amp_q != {1'b1, {(DW-1){1'b0}}});

  // R11: the first and last quarter of the cosine are positive.
  assert_cos_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sine_i && (addr_i[AW-1] == addr_i[AW-2])) |=> (amp_q >= 0));

endmodule

// File: rtl/sweep_dds_core.sv
`timescale 1ns/1ps
module sweep_dds_core #(
  parameter int FW = 32,
  parameter int PW = 32,
  parameter int RW = 16,
  parameter int AW = 10,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic [FW-1:0]        pend_start_i,
  input  logic [FW-1:0]        pend_end_i,
  input  logic [FW-1:0]        pend_step_i,
  input  logic [RW-1:0]        pend_ramp_i,
  input  logic                 pend_sweep_i,
  input  logic                 pend_fhold_i,
  input  logic                 pend_phold_i,
  input  logic                 pend_fauto_i,
  input  logic                 pend_pauto_i,
  input  logic                 pend_rreload_i,
  input  logic                 pend_sine_i,
  output logic [FW-1:0]        ftw_o,
  output logic [PW-1:0]        phase_o,
  output logic signed [DW-1:0] amp_o
);
  import sdds_pkg::*;

  // Active settings, loaded on the update strobe.
  sdds_ctl_t     pend_ctl;
  sdds_ctl_t     act_ctl_q;
  logic [FW-1:0] act_start_q;
  logic [FW-1:0] act_end_q;
  logic [FW-1:0] act_step_q;
  logic [RW-1:0] act_ramp_q;

  assign pend_ctl = '{sweep:   pend_sweep_i,
                      fhold:   pend_fhold_i,
                      phold:   pend_phold_i,
                      fauto:   pend_fauto_i,
                      pauto:   pend_pauto_i,
                      rreload: pend_rreload_i,
                      sine:    pend_sine_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctl_q   <= '0;
      act_start_q <= '0;
      act_end_q   <= '0;
      act_step_q  <= '0;
      act_ramp_q  <= '0;
    end else if (upd_i) begin
      act_ctl_q   <= pend_ctl;
      act_start_q <= pend_start_i;
      act_end_q   <= pend_end_i;
      act_step_q  <= pend_step_i;
      act_ramp_q  <= pend_ramp_i;
    end
  end

  // Strobe-driven actions take their enables from the settings being applied.
  logic fclr_stb;
  logic pclr_stb;
  logic rld_stb;
  logic park;
  logic restart;
  logic tick;

  assign fclr_stb = upd_i & pend_fauto_i & ~act_ctl_q.fhold;
  assign pclr_stb = upd_i & pend_pauto_i & ~act_ctl_q.phold;
  assign rld_stb  = upd_i & pend_rreload_i;
  assign park     = act_ctl_q.fhold | (~act_ctl_q.sweep & ~fclr_stb);
  assign restart  = fclr_stb | rld_stb;

  sdds_ramp_timer #(.RW(RW)) u_ramp (
    .clk           (clk),
    .rst_n         (rst_n),
    .park_i        (park),
    .restart_i     (restart),
    .restart_val_i (pend_ramp_i),
    .ramp_val_i    (act_ramp_q),
    .tick_o        (tick)
  );

  sdds_freq_sweep #(.FW(FW)) u_freq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (act_ctl_q.fhold),
    .clr_i   (fclr_stb),
    .tick_i  (tick),
    .start_i (act_start_q),
    .end_i   (act_end_q),
    .step_i  (act_step_q),
    .ftw_o   (ftw_o)
  );

  sdds_phase_acc #(.PW(PW), .FW(FW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (act_ctl_q.phold),
    .clr_i   (pclr_stb),
    .ftw_i   (ftw_o),
    .phase_o (phase_o)
  );

  sdds_amp_lut #(.AW(AW), .DW(DW)) u_lut (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (phase_o[PW-1 -: AW]),
    .sine_i (act_ctl_q.sine),
    .amp_o  (amp_o)
  );

  // R2: without a strobe the active settings do not move.
  assert_settings_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(act_ctl_q) && $stable(act_start_q) && $stable(act_end_q)
                && $stable(act_step_q) && $stable(act_ramp_q)));

  // R12: with sweep off and no strobe, the tuning word holds.
  assert_sweep_off_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_ctl_q.sweep && !act_ctl_q.fhold && !upd_i) |=> $stable(ftw_o));

endmodule

// File: tb/test_sweep_dds_core.sv
`timescale 1ns/1ps
module test_sweep_dds_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [31:0] p_start = '0, p_end = '0, p_step = '0;
  logic [15:0] p_ramp = '0;
  logic        p_sweep = 0, p_fh = 0, p_ph = 0, p_fa = 0, p_pa = 0, p_rl = 0, p_sine = 0;
  logic [31:0] ftw, phase;
  logic signed [11:0] amp;

  int checks = 0;
  int errors = 0;
  string t_ftw = "R1", t_ph = "R1", t_amp = "R1";

  always #5 clk = ~clk;

  sweep_dds_core i_sweep_dds_core (
    .clk(clk), .rst_n(rst_n), .upd_i(upd),
    .pend_start_i(p_start), .pend_end_i(p_end), .pend_step_i(p_step),
    .pend_ramp_i(p_ramp), .pend_sweep_i(p_sweep), .pend_fhold_i(p_fh),
    .pend_phold_i(p_ph), .pend_fauto_i(p_fa), .pend_pauto_i(p_pa),
    .pend_rreload_i(p_rl), .pend_sine_i(p_sine),
    .ftw_o(ftw), .phase_o(phase), .amp_o(amp)
  );

  // Reference model built from the requirements.
  logic [31:0] m_start, m_end, m_step, m_off, m_ph;
  logic [15:0] m_ramp, m_rc;
  logic        m_sweep, m_fh, m_phd, m_sine;
  int          m_amp;

  function automatic int ref_amp(input logic [9:0] p, input logic sine);
    real th, v, s;
    th = 2.0 * 3.14159265358979323846 * (p + 0.5) / 1024.0;
    v  = sine ? $sin(th) : $cos(th);
    s  = 2047.0 * v;
    return (s < 0.0) ? -$rtoi(-s + 0.5) : $rtoi(s + 0.5);
  endfunction

  function automatic logic [31:0] clamp_step(input logic [31:0] off, input logic [31:0] st,
                                             input logic [31:0] s, input logic [31:0] e);
    logic [31:0] span;
    logic [32:0] sum;
    span = (e >= s) ? e - s : 32'd0;
    sum  = {1'b0, off} + {1'b0, st};
    return (sum > {1'b0, span}) ? span : sum[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start <= '0; m_end <= '0; m_step <= '0; m_ramp <= '0;
      m_sweep <= 0; m_fh <= 0; m_phd <= 0; m_sine <= 0;
      m_off <= '0; m_rc <= '0; m_ph <= '0; m_amp <= 0;
    end else begin
      if (m_fh) begin
        m_off <= '0; m_rc <= m_ramp;
      end else if (upd && p_fa) begin
        m_off <= '0; m_rc <= p_ramp;
      end else if (!m_sweep) begin
        m_rc <= m_ramp;
      end else if (upd && p_rl) begin
        m_rc <= p_ramp;
      end else if (m_rc == 0) begin
        m_off <= clamp_step(m_off, m_step, m_start, m_end);
        m_rc  <= m_ramp;
      end else begin
        m_rc <= m_rc - 1'b1;
      end
      if (m_phd || (upd && p_pa)) m_ph <= '0;
      else                        m_ph <= m_ph + m_start + m_off;
      m_amp <= ref_amp(m_ph[31:22], m_sine);
      if (upd) begin
        m_start <= p_start; m_end <= p_end; m_step <= p_step; m_ramp <= p_ramp;
        m_sweep <= p_sweep; m_fh <= p_fh; m_phd <= p_ph; m_sine <= p_sine;
      end
    end
  end

  task automatic compare();
    int d;
    checks += 3;
    if (ftw !== m_start + m_off) begin
      errors++;
      $display("FAIL %s ftw got %h expected %h", t_ftw, ftw, m_start + m_off);
    end
    if (phase !== m_ph) begin
      errors++;
      $display("FAIL %s phase got %h expected %h", t_ph, phase, m_ph);
    end
    d = int'(amp) - m_amp;
    if (d > 1 || d < -1) begin
      errors++;
      $display("FAIL %s amp got %0d expected %0d", t_amp, amp, m_amp);
    end
  endtask

  task automatic step(input logic u);
    upd = u;
    @(posedge clk);
    @(negedge clk);
    upd = 1'b0;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic tags(input string a, input string b, input string c);
    t_ftw = a; t_ph = b; t_amp = c;
  endtask

  task automatic clear_bits();
    p_fh = 0; p_ph = 0; p_fa = 0; p_pa = 0; p_rl = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: reset values
    repeat (3) @(negedge clk);
    tags("R1", "R1", "R1");
    compare();
    checks++;
    if (amp !== 12'sd0) begin
      errors++;
      $display("FAIL R1 amp got %0d expected 0", amp);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R10, R11, R12: fixed tone, sweep off, cosine
    tags("R12", "R10", "R11");
    p_start = 32'h0123_4567; p_end = 32'hFFFF_FFFF; p_step = 32'h0010_0000; p_ramp = 16'd3;
    p_sweep = 0; p_sine = 0; clear_bits();
    step(1'b1);
    run(60);

    // R11: sine select
    tags("R12", "R10", "R11");
    p_sine = 1; step(1'b1);
    run(60);

    // R3: sweep with ramp 3
    tags("R3", "R10", "R11");
    p_sweep = 1; p_start = 32'h0100_0000; p_end = 32'h4000_0000; p_ramp = 16'd3;
    step(1'b1);
    run(40);

    // R2: pending changes without strobe have no effect
    tags("R2", "R2", "R2");
    p_step = 32'h7000_0000; p_ramp = 16'd0; p_start = 32'h0; p_sine = 0; p_fh = 1;
    run(20);
    p_fh = 0;

    // R5: narrow span clamps at the end word
    tags("R5", "R10", "R11");
    p_start = 32'h1000_0000; p_end = 32'h1030_0000; p_step = 32'h0011_0000; p_ramp = 16'd1;
    step(1'b1);
    run(30);
    p_end = 32'h0800_0000; step(1'b1); run(10);   // end below start: span zero

    // R4: reload restarts the countdown, steps never complete
    tags("R4", "R10", "R11");
    p_start = 32'h0200_0000; p_end = 32'hF000_0000; p_step = 32'h0001_0000; p_ramp = 16'd5;
    step(1'b1);
    p_rl = 1;
    for (int i = 0; i < 8; i++) begin step(1'b1); step(1'b0); end
    p_rl = 0;
    for (int i = 0; i < 8; i++) begin step(1'b1); step(1'b0); end

    // R6: frequency auto-clear
    tags("R6", "R10", "R11");
    run(20);
    p_fa = 1; step(1'b1); p_fa = 0; run(15);

    // R7: phase auto-clear
    tags("R6", "R7", "R11");
    p_pa = 1; step(1'b1); p_pa = 0; run(10);

    // R8: strobes without auto-clear leave the accumulators alone
    tags("R8", "R8", "R11");
    for (int i = 0; i < 6; i++) begin step(1'b1); run(3); end

    // R9: static clears, also overriding strobe clears
    tags("R9", "R9", "R11");
    p_fh = 1; p_ph = 1; step(1'b1); run(5);
    p_fa = 1; p_pa = 1; step(1'b1); step(1'b1); run(5);
    clear_bits(); step(1'b1); run(20);

    // Random strobes and settings
    tags("R3", "R10", "R11");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) begin
        p_start = $urandom();
        p_end   = ($urandom_range(9) == 0) ? $urandom() : p_start + ($urandom() >> 3);
        p_step  = $urandom() >> $urandom_range(4, 12);
        p_ramp  = 16'($urandom_range(7));
        p_sweep = ($urandom_range(3) != 0);
        p_fh    = ($urandom_range(7) == 0);
        p_ph    = ($urandom_range(7) == 0);
        p_fa    = ($urandom_range(3) == 0);
        p_pa    = ($urandom_range(3) == 0);
        p_rl    = ($urandom_range(3) == 0);
        p_sine  = 1'($urandom_range(1));
        step(1'b1);
      end else begin
        step(1'b0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule